// File: doc/BRIEF.md
# Front-End Controller Register Bank

This block is the addressed register file of a front-end board controller. It sees one already decoded transaction per cycle. Each transaction carries a 7-bit address, 16-bit write data, a write flag, a broadcast flag and a source flag. The source flag says whether the access came over the serial management bus or over the main readout bus. The block holds the writable thresholds, configuration words and front-end timing words, each with its own reset value and bit width. It returns live values for read-only monitor, counter and status words that are supplied from outside. It also turns writes to the ten data-less command addresses into single-cycle strobes.

Access is filtered per address. The serial management bus cannot reach the main-bus-only commands or the front-end timing block. A broadcast cannot touch the read-only monitor and counter words. A refused access changes nothing and raises a one-cycle error pulse. Every response, whether read data, error or command strobe, is registered and appears in the cycle after the request.

Top module: `fe_regbank`

## Requirements
- R1: After reset, reads return the reset values. Examples: config word 0 (address 0x11) reads 0x07FF, config word 2 (0x13) reads 0x000F, config word 3 (0x14) reads 0x2220, the hold-wait word (0x22) reads 0x0020, the second trigger timeout (0x24) reads 0x0E00 and the multi-event word (0x4C) reads 0x0144. A later reset restores these values.
- R2: A write to a writable address is kept masked to that register's width: 10 bits for thresholds, 11 bits for 0x11 and 9 bits for 0x0F and 0x4C. A read returns zero in the unused upper bits.
- R3: Reads of read-only addresses return the current external input, zero-extended. These are the monitor words (0x06-0x0A, 0x32-0x36, 0x3C-0x40, 0x46-0x4A, slot order ascending), the counters (0x0B-0x0E as slots 0-3, 0x21 as slot 4), status word 1 (0x12) and the front-end status word (0x20). Writes to these addresses are ignored.
- R4: An accepted write to command address 0x16+k (k = 0..9) raises `cmd_pulse[k]` for exactly one cycle. Reading a command address returns zero and raises no strobe.
- R5: A serial-bus access to 0x1C-0x2C, 0x4B or 0x4C is refused. Serial-bus accesses to other addresses are accepted.
- R6: A broadcast access to a monitor address or to 0x0B-0x0E is refused.
- R7: Broadcast writes to writable and command addresses take effect. An accepted broadcast read raises neither `rd_valid` nor `acc_err`.
- R8: Bit 0 of config word 2 (0x13) is always 1, whatever value is written.
- R9: Reads of unmapped addresses, and of the unused word at 0x15, return zero with `rd_valid` high. Writes to these addresses are ignored and raise no error.
- R10: Responses are registered: one cycle after the request. `rd_valid` comes only from accepted non-broadcast reads, `rd_data` is zero when `rd_valid` is low, and `acc_err` never coincides with `rd_valid` or a strobe. With no request, all three response outputs are zero.
- R11: The configuration outputs `cfg_thr`, `cfg_csr0`, `cfg_csr2`, `cfg_csr3` and `cfg_fmd` follow the stored register contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Transaction present this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_bcast | input | 1 | Transaction is a broadcast |
| req_serial | input | 1 | 1 = serial management bus, 0 = main bus |
| req_addr | input | 7 | Register address |
| req_wdata | input | 16 | Write data |
| mon_vals | input | 200 | Twenty 10-bit monitor values, slot 0 in the low bits |
| cnt_vals | input | 80 | Five 16-bit counter values |
| stat_csr1 | input | 14 | Live status word 1 |
| stat_fmd | input | 16 | Live front-end status word |
| rd_valid | output | 1 | Read response valid |
| rd_data | output | 16 | Read response data |
| acc_err | output | 1 | Refused access, one cycle |
| cmd_pulse | output | 10 | One-cycle command strobes |
| cfg_thr | output | 200 | Twenty 10-bit thresholds, slot order as the monitors |
| cfg_csr0 | output | 11 | Config word 0 |
| cfg_csr2 | output | 16 | Config word 2 |
| cfg_csr3 | output | 16 | Config word 3 |
| cfg_fmd | output | 208 | Front-end words 0x22-0x2C, then 0x4B, 0x4C |

## Verification
The assertions check the following on every cycle:
- the command strobes are at most one-hot;
- a strobe, an error or a read response never appears without a matching request in the cycle before;
- refusals and read data are mutually exclusive;
- the regulator bit stays set;
- broadcast accesses to monitor addresses are refused;
- unmapped reads return zero;
- configuration state holds while no write is enabled.

Only the bench scenarios can show the following: the exact reset values, the width masking of each register class, the mapping of monitor and counter slots to addresses, the position of each command strobe, the full source and broadcast filter tables, and the fact that a refused write leaves the target register unchanged.

// File: rtl/fe_regbank_pkg.sv
package fe_regbank_pkg;
  localparam int ADDR_W    = 7;
  localparam int DATA_W    = 16;
  localparam int MON_W     = 10;
  localparam int GRP_SZ    = 5;
  localparam int N_GRP     = 4;
  localparam int N_MON     = N_GRP * GRP_SZ;
  localparam int N_CNT     = 5;
  localparam int N_CMD     = 10;
  localparam int N_FMD     = 13;
  localparam int STAT1_W   = 14;
  localparam int CSR0_W    = 11;
  localparam int NREG      = 1 << ADDR_W;
  localparam int MON_IDX_W = $clog2(N_MON);
  localparam int CNT_IDX_W = $clog2(N_CNT);

  localparam int A_CSR0     = 'h11;
  localparam int A_STAT1    = 'h12;
  localparam int A_CSR2     = 'h13;
  localparam int A_CSR3     = 'h14;
  localparam int A_CMD_BASE = 'h16;
  localparam int A_MAINONLY = 'h1C;
  localparam int A_FSTAT    = 'h20;
  localparam int A_FMD_LO   = 'h22;
  localparam int A_FMD_HI   = 'h2C;
  localparam int A_CALIT    = 'h4B;
  localparam int A_MEB      = 'h4C;

  typedef logic [ADDR_W-1:0] addr_t;
  typedef logic [DATA_W-1:0] data_t;
  typedef enum logic [2:0] {K_NONE, K_RW, K_MON, K_CNT, K_STAT1, K_FSTAT, K_CMD} kind_e;

  // Each monitor group: five thresholds followed by the five matching live values.
  function automatic int thr_base(int g);
    case (g)
      0:       return 'h01;
      1:       return 'h2D;
      2:       return 'h37;
      default: return 'h41;
    endcase
  endfunction

  function automatic int thr_group(addr_t a);
    int ai = int'(a);
    for (int g = 0; g < N_GRP; g++)
      if (ai >= thr_base(g) && ai < thr_base(g) + GRP_SZ) return g;
    return -1;
  endfunction

  function automatic int mon_index(addr_t a);
    int ai = int'(a);
    for (int g = 0; g < N_GRP; g++)
      if (ai >= thr_base(g) + GRP_SZ && ai < thr_base(g) + 2 * GRP_SZ)
        return g * GRP_SZ + ai - thr_base(g) - GRP_SZ;
    return -1;
  endfunction

  function automatic logic [MON_IDX_W-1:0] mon_slot(addr_t a);
    int m = mon_index(a);
    return (m < 0) ? '0 : MON_IDX_W'(m);
  endfunction

  function automatic logic [CNT_IDX_W-1:0] cnt_slot(addr_t a);
    int ai = int'(a);
    return (ai >= 'h0B && ai <= 'h0E) ? CNT_IDX_W'(ai - 'h0B) : CNT_IDX_W'(N_CNT - 1);
  endfunction

  function automatic addr_t thr_addr(int i);
    return addr_t'(thr_base(i / GRP_SZ) + i % GRP_SZ);
  endfunction

  function automatic addr_t fmd_addr(int i);
    if (i <= A_FMD_HI - A_FMD_LO) return addr_t'(A_FMD_LO + i);
    return (i == N_FMD - 2) ? addr_t'(A_CALIT) : addr_t'(A_MEB);
  endfunction

  function automatic kind_e reg_kind(addr_t a);
    int ai = int'(a);
    if (thr_group(a) >= 0) return K_RW;
    if (mon_index(a) >= 0) return K_MON;
    if ((ai >= 'h0B && ai <= 'h0E) || ai == 'h21) return K_CNT;
    if (ai == 'h0F || ai == 'h10 || ai == A_CSR0 || ai == A_CSR2 || ai == A_CSR3) return K_RW;
    if (ai == A_STAT1) return K_STAT1;
    if (ai >= A_CMD_BASE && ai < A_CMD_BASE + N_CMD) return K_CMD;
    if (ai == A_FSTAT) return K_FSTAT;
    if ((ai >= A_FMD_LO && ai <= A_FMD_HI) || ai == A_CALIT || ai == A_MEB) return K_RW;
    return K_NONE;
  endfunction

  function automatic data_t width_mask(addr_t a);
    int ai = int'(a);
    if (thr_group(a) >= 0) return data_t'((1 << MON_W) - 1);
    if (ai == 'h0F || ai == A_MEB) return 16'h01FF;
    if (ai == A_CSR0) return data_t'((1 << CSR0_W) - 1);
    if (reg_kind(a) == K_RW) return '1;
    return '0;
  endfunction

  function automatic data_t reg_default(addr_t a);
    int ai = int'(a);
    int g  = thr_group(a);
    int s;
    if (g >= 0) begin
      s = ai - thr_base(g);
      if (s == 0) return 16'h00A0;
      case (g)
        0:       return 16'h03FF;
        1:       return (s <= 3) ? 16'h03FF : 16'h0000;
        2:       return (s <= 2) ? 16'h01FF : 16'h0000;
        default: return (s <= 2) ? 16'h0000 : 16'h03FF;
      endcase
    end
    case (ai)
      'h0F, 'h10: return 16'h0001;
      'h11:       return 16'h07FF;
      'h13:       return 16'h000F;
      'h14:       return 16'h2220;
      'h22:       return 16'h0020;
      'h23:       return 16'h00F0;
      'h24:       return 16'h0E00;
      'h25:       return 16'h1000;
      'h26:       return 16'h7F00;
      'h27:       return 16'h2000;
      'h28:       return 16'h2A20;
      'h29:       return 16'h645D;
      'h2A:       return 16'h878B;
      'h2B:       return 16'h0402;
      'h4B:       return 16'h0064;
      'h4C:       return 16'h0144;
      default:    return 16'h0000;
    endcase
  endfunction

  function automatic logic serial_ok(addr_t a);
    int ai = int'(a);
    return !((ai >= A_MAINONLY && ai <= A_FMD_HI) || ai == A_CALIT || ai == A_MEB);
  endfunction

  function automatic logic bcast_ok(addr_t a);
    int ai = int'(a);
    return !(reg_kind(a) == K_MON || (ai >= 'h0B && ai <= 'h0E));
  endfunction
endpackage

// File: rtl/fe_access_check.sv
module fe_access_check
  import fe_regbank_pkg::*;
(
  input  logic  req_valid,
  input  logic  req_write,
  input  logic  req_bcast,
  input  logic  req_serial,
  input  addr_t req_addr,
  output kind_e kind,
  output logic  deny,
  output logic  wr_en,
  output logic  cmd_en,
  output logic  rd_en
);
  logic path_ok;
  logic cast_ok;

  always_comb begin
    kind    = reg_kind(req_addr);
    path_ok = !req_serial || serial_ok(req_addr);
    cast_ok = !req_bcast || bcast_ok(req_addr);
    deny    = req_valid && !(path_ok && cast_ok);
    wr_en   = req_valid && !deny && req_write && (kind == K_RW);
    cmd_en  = req_valid && !deny && req_write && (kind == K_CMD);
    rd_en   = req_valid && !deny && !req_write && !req_bcast;
  end
endmodule

// File: rtl/fe_cfg_store.sv
module fe_cfg_store
  import fe_regbank_pkg::*;
(
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   wr_en,
  input  addr_t                  wr_addr,
  input  data_t                  wr_data,
  input  addr_t                  rd_addr,
  output data_t                  rd_data,
  output logic [N_MON*MON_W-1:0] cfg_thr,
  output logic [CSR0_W-1:0]      cfg_csr0,
  output data_t                  cfg_csr2,
  output data_t                  cfg_csr3,
  output logic [N_FMD*DATA_W-1:0] cfg_fmd
);
  data_t mem_q [NREG];
  data_t wr_val;

  always_comb begin
    wr_val = wr_data & width_mask(wr_addr);
    if (int'(wr_addr) == A_CSR2) wr_val[0] = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NREG; i++) mem_q[i] <= reg_default(addr_t'(i));
    end else if (wr_en) begin
      mem_q[wr_addr] <= wr_val;
    end
  end

  assign rd_data  = mem_q[rd_addr];
  assign cfg_csr0 = mem_q[A_CSR0][CSR0_W-1:0];
  assign cfg_csr2 = mem_q[A_CSR2];
  assign cfg_csr3 = mem_q[A_CSR3];

  for (genvar i = 0; i < N_MON; i++) begin : g_thr
    assign cfg_thr[i*MON_W +: MON_W] = mem_q[thr_addr(i)][MON_W-1:0];
  end

  for (genvar i = 0; i < N_FMD; i++) begin : g_fmd
    assign cfg_fmd[i*DATA_W +: DATA_W] = mem_q[fmd_addr(i)];
  end

  // R8: the regulator enable never drops
  p_regulator_on_r8: assert property (@(posedge clk) disable iff (rst) cfg_csr2[0]);
  // R5/R11: configuration holds while no write is enabled
  p_hold_cfg_r11: assert property (@(posedge clk) disable iff (rst)
    !wr_en |=> ($stable(cfg_csr0) && $stable(cfg_csr2) && $stable(cfg_csr3)));
endmodule

// File: rtl/fe_cmd_strobe.sv
module fe_cmd_strobe
  import fe_regbank_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             cmd_en,
  input  addr_t            cmd_addr,
  output logic [N_CMD-1:0] pulse_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      pulse_q <= '0;
    end else begin
      for (int i = 0; i < N_CMD; i++)
        pulse_q[i] <= cmd_en && (int'(cmd_addr) == A_CMD_BASE + i);
    end
  end

  // R4: at most one command strobe per cycle
  p_cmd_onehot_r4: assert property (@(posedge clk) disable iff (rst) $onehot0(pulse_q));
  // R4: a strobe always follows an accepted command write
  p_cmd_cause_r4: assert property (@(posedge clk) disable iff (rst)
    (pulse_q != '0) |-> $past(cmd_en));
endmodule

// File: rtl/fe_regbank.sv
module fe_regbank
  import fe_regbank_pkg::*;
(
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     req_valid,
  input  logic                     req_write,
  input  logic                     req_bcast,
  input  logic                     req_serial,
  input  logic [ADDR_W-1:0]        req_addr,
  input  logic [DATA_W-1:0]        req_wdata,
  input  logic [N_MON*MON_W-1:0]   mon_vals,
  input  logic [N_CNT*DATA_W-1:0]  cnt_vals,
  input  logic [STAT1_W-1:0]       stat_csr1,
  input  logic [DATA_W-1:0]        stat_fmd,
  output logic                     rd_valid,
  output logic [DATA_W-1:0]        rd_data,
  output logic                     acc_err,
  output logic [N_CMD-1:0]         cmd_pulse,
  output logic [N_MON*MON_W-1:0]   cfg_thr,
  output logic [CSR0_W-1:0]        cfg_csr0,
  output logic [DATA_W-1:0]        cfg_csr2,
  output logic [DATA_W-1:0]        cfg_csr3,
  output logic [N_FMD*DATA_W-1:0]  cfg_fmd
);
  kind_e kind;
  logic  deny, wr_en, cmd_en, rd_en;
  data_t store_rd;
  data_t rd_next;

  fe_access_check u_check (
    .req_valid (req_valid),
    .req_write (req_write),
    .req_bcast (req_bcast),
    .req_serial(req_serial),
    .req_addr  (req_addr),
    .kind      (kind),
    .deny      (deny),
    .wr_en     (wr_en),
    .cmd_en    (cmd_en),
    .rd_en     (rd_en)
  );

  fe_cfg_store u_store (
    .clk     (clk),
    .rst     (rst),
    .wr_en   (wr_en),
    .wr_addr (req_addr),
    .wr_data (req_wdata),
    .rd_addr (req_addr),
    .rd_data (store_rd),
    .cfg_thr (cfg_thr),
    .cfg_csr0(cfg_csr0),
    .cfg_csr2(cfg_csr2),
    .cfg_csr3(cfg_csr3),
    .cfg_fmd (cfg_fmd)
  );

  fe_cmd_strobe u_cmd (
    .clk     (clk),
    .rst     (rst),
    .cmd_en  (cmd_en),
    .cmd_addr(req_addr),
    .pulse_q (cmd_pulse)
  );

  always_comb begin
    case (kind)
      K_RW:    rd_next = store_rd;
      K_MON:   rd_next = data_t'(mon_vals[int'(mon_slot(req_addr))*MON_W +: MON_W]);
      K_CNT:   rd_next = cnt_vals[int'(cnt_slot(req_addr))*DATA_W +: DATA_W];
      K_STAT1: rd_next = data_t'(stat_csr1);
      K_FSTAT: rd_next = stat_fmd;
      default: rd_next = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_valid <= 1'b0;
      rd_data  <= '0;
      acc_err  <= 1'b0;
    end else begin
      rd_valid <= rd_en;
      rd_data  <= rd_en ? rd_next : '0;
      acc_err  <= deny;
    end
  end

  // R10: refusal never coincides with data or a strobe
  p_err_excl_r10: assert property (@(posedge clk) disable iff (rst)
    acc_err |-> (!rd_valid && cmd_pulse == '0));
  // R10: read data only answers a non-broadcast read
  p_rd_cause_r10: assert property (@(posedge clk) disable iff (rst)
    rd_valid |-> $past(req_valid && !req_write && !req_bcast));
  // R10: quiet request cycle gives quiet response
  p_idle_r10: assert property (@(posedge clk) disable iff (rst)
    !req_valid |=> (!rd_valid && !acc_err && cmd_pulse == '0));
  // R6: broadcast to a monitor word is refused
  p_bcast_mon_r6: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_bcast && kind == K_MON) |=> acc_err);
  // R9: unmapped reads return zero
  p_unmapped_zero_r9: assert property (@(posedge clk) disable iff (rst)
    (rd_valid && $past(kind == K_NONE)) |-> (rd_data == '0));
endmodule

// File: tb/fe_regbank_bench.sv
module fe_regbank_bench;
  localparam int VW    = 58;
  localparam int N_VEC = 48;

  // {wr,bc,ser} addr wdata {exp_valid,exp_err} exp_data exp_cmd req
  localparam logic [VW-1:0] VEC [N_VEC] = '{
    {3'b000, 7'h11, 16'h0000, 2'b10, 16'h07FF, 10'h000, 4'd1},  // R1
    {3'b000, 7'h14, 16'h0000, 2'b10, 16'h2220, 10'h000, 4'd1},
    {3'b000, 7'h24, 16'h0000, 2'b10, 16'h0E00, 10'h000, 4'd1},
    {3'b000, 7'h4C, 16'h0000, 2'b10, 16'h0144, 10'h000, 4'd1},
    {3'b100, 7'h01, 16'hFFFF, 2'b00, 16'h0000, 10'h000, 4'd2},  // R2
    {3'b000, 7'h01, 16'h0000, 2'b10, 16'h03FF, 10'h000, 4'd2},
    {3'b100, 7'h11, 16'h1234, 2'b00, 16'h0000, 10'h000, 4'd2},
    {3'b000, 7'h11, 16'h0000, 2'b10, 16'h0234, 10'h000, 4'd2},
    {3'b100, 7'h4C, 16'hABCD, 2'b00, 16'h0000, 10'h000, 4'd2},
    {3'b000, 7'h4C, 16'h0000, 2'b10, 16'h01CD, 10'h000, 4'd2},
    {3'b000, 7'h07, 16'h0000, 2'b10, 16'h002A, 10'h000, 4'd3},  // R3
    {3'b100, 7'h07, 16'h0155, 2'b00, 16'h0000, 10'h000, 4'd3},
    {3'b000, 7'h07, 16'h0000, 2'b10, 16'h002A, 10'h000, 4'd3},
    {3'b000, 7'h0D, 16'h0000, 2'b10, 16'h1002, 10'h000, 4'd3},
    {3'b000, 7'h12, 16'h0000, 2'b10, 16'h1ABC, 10'h000, 4'd3},
    {3'b000, 7'h20, 16'h0000, 2'b10, 16'hBEEF, 10'h000, 4'd3},
    {3'b000, 7'h21, 16'h0000, 2'b10, 16'h1004, 10'h000, 4'd3},
    {3'b000, 7'h46, 16'h0000, 2'b10, 16'h0230, 10'h000, 4'd3},
    {3'b100, 7'h16, 16'h0000, 2'b00, 16'h0000, 10'h001, 4'd4},  // R4
    {3'b100, 7'h1B, 16'h0000, 2'b00, 16'h0000, 10'h020, 4'd4},
    {3'b100, 7'h1F, 16'h0000, 2'b00, 16'h0000, 10'h200, 4'd4},
    {3'b000, 7'h18, 16'h0000, 2'b10, 16'h0000, 10'h000, 4'd4},
    {3'b101, 7'h1F, 16'h0000, 2'b01, 16'h0000, 10'h000, 4'd5},  // R5
    {3'b001, 7'h24, 16'h0000, 2'b01, 16'h0000, 10'h000, 4'd5},
    {3'b101, 7'h22, 16'h5555, 2'b01, 16'h0000, 10'h000, 4'd5},
    {3'b000, 7'h22, 16'h0000, 2'b10, 16'h0020, 10'h000, 4'd5},
    {3'b101, 7'h4B, 16'h1111, 2'b01, 16'h0000, 10'h000, 4'd5},
    {3'b001, 7'h11, 16'h0000, 2'b10, 16'h0234, 10'h000, 4'd5},
    {3'b101, 7'h1B, 16'h0000, 2'b00, 16'h0000, 10'h020, 4'd5},
    {3'b010, 7'h07, 16'h0000, 2'b01, 16'h0000, 10'h000, 4'd6},  // R6
    {3'b110, 7'h0C, 16'h0001, 2'b01, 16'h0000, 10'h000, 4'd6},
    {3'b010, 7'h4A, 16'h0000, 2'b01, 16'h0000, 10'h000, 4'd6},
    {3'b110, 7'h02, 16'h0123, 2'b00, 16'h0000, 10'h000, 4'd7},  // R7
    {3'b000, 7'h02, 16'h0000, 2'b10, 16'h0123, 10'h000, 4'd7},
    {3'b010, 7'h11, 16'h0000, 2'b00, 16'h0000, 10'h000, 4'd7},
    {3'b110, 7'h17, 16'h0000, 2'b00, 16'h0000, 10'h002, 4'd7},
    {3'b010, 7'h21, 16'h0000, 2'b00, 16'h0000, 10'h000, 4'd7},
    {3'b100, 7'h13, 16'h0000, 2'b00, 16'h0000, 10'h000, 4'd8},  // R8
    {3'b000, 7'h13, 16'h0000, 2'b10, 16'h0001, 10'h000, 4'd8},
    {3'b100, 7'h13, 16'hF0F0, 2'b00, 16'h0000, 10'h000, 4'd8},
    {3'b000, 7'h13, 16'h0000, 2'b10, 16'hF0F1, 10'h000, 4'd8},
    {3'b000, 7'h00, 16'h0000, 2'b10, 16'h0000, 10'h000, 4'd9},  // R9
    {3'b000, 7'h15, 16'h0000, 2'b10, 16'h0000, 10'h000, 4'd9},
    {3'b000, 7'h7F, 16'h0000, 2'b10, 16'h0000, 10'h000, 4'd9},
    {3'b100, 7'h50, 16'hFFFF, 2'b00, 16'h0000, 10'h000, 4'd9},
    {3'b000, 7'h50, 16'h0000, 2'b10, 16'h0000, 10'h000, 4'd9},
    {3'b100, 7'h15, 16'hFFFF, 2'b00, 16'h0000, 10'h000, 4'd9},
    {3'b000, 7'h15, 16'h0000, 2'b10, 16'h0000, 10'h000, 4'd9}
  };

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         req_valid = 1'b0, req_write = 1'b0, req_bcast = 1'b0, req_serial = 1'b0;
  logic [6:0]   req_addr = '0;
  logic [15:0]  req_wdata = '0;
  logic [199:0] mon_vals;
  logic [79:0]  cnt_vals;
  logic [13:0]  stat_csr1 = 14'h1ABC;
  logic [15:0]  stat_fmd = 16'hBEEF;
  logic         rd_valid, acc_err;
  logic [15:0]  rd_data, cfg_csr2, cfg_csr3;
  logic [9:0]   cmd_pulse;
  logic [199:0] cfg_thr;
  logic [10:0]  cfg_csr0;
  logic [207:0] cfg_fmd;
  int n_tests = 0;
  int n_fail  = 0;

  always #2 clk = ~clk;

  fe_regbank u_fe_regbank (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_write(req_write),
    .req_bcast(req_bcast), .req_serial(req_serial), .req_addr(req_addr),
    .req_wdata(req_wdata), .mon_vals(mon_vals), .cnt_vals(cnt_vals),
    .stat_csr1(stat_csr1), .stat_fmd(stat_fmd), .rd_valid(rd_valid),
    .rd_data(rd_data), .acc_err(acc_err), .cmd_pulse(cmd_pulse),
    .cfg_thr(cfg_thr), .cfg_csr0(cfg_csr0), .cfg_csr2(cfg_csr2),
    .cfg_csr3(cfg_csr3), .cfg_fmd(cfg_fmd)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic issue(input logic w, input logic b, input logic s,
                       input logic [6:0] a, input logic [15:0] d);
    @(negedge clk);
    req_valid = 1'b1; req_write = w; req_bcast = b; req_serial = s;
    req_addr = a; req_wdata = d;
    @(negedge clk);
    req_valid = 1'b0; req_write = 1'b0; req_bcast = 1'b0; req_serial = 1'b0;
  endtask

  initial begin
    for (int i = 0; i < 20; i++) mon_vals[i*10 +: 10] = 10'(i * 37 + 5);
    for (int i = 0; i < 5; i++)  cnt_vals[i*16 +: 16] = 16'(16'h1000 + i);
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 / R10: reset state at the ports
    chk({rd_valid, acc_err, cmd_pulse} == '0, "R10 reset outputs",
        32'({rd_valid, acc_err, cmd_pulse}), 32'h0);
    chk(cfg_csr0 == 11'h7FF, "R1 csr0 default", 32'(cfg_csr0), 32'h7FF);
    chk(cfg_csr2 == 16'h000F, "R1 csr2 default", 32'(cfg_csr2), 32'h000F);
    chk(cfg_csr3 == 16'h2220, "R1 csr3 default", 32'(cfg_csr3), 32'h2220);
    chk(cfg_fmd[15:0] == 16'h0020, "R1 hold-wait default", 32'(cfg_fmd[15:0]), 32'h0020);
    chk(cfg_thr[9:0] == 10'h0A0, "R1 temp threshold default", 32'(cfg_thr[9:0]), 32'h0A0);

    for (int i = 0; i < N_VEC; i++) begin
      issue(VEC[i][57], VEC[i][56], VEC[i][55], VEC[i][54:48], VEC[i][47:32]);
      chk({rd_valid, acc_err, rd_data, cmd_pulse} == VEC[i][31:4],
          $sformatf("R%0d vector %0d", VEC[i][3:0], i),
          {4'b0, rd_valid, acc_err, rd_data, cmd_pulse}, {4'b0, VEC[i][31:4]});
    end

    // R11: configuration outputs follow stored values
    chk(cfg_csr0 == 11'h234, "R11 cfg_csr0", 32'(cfg_csr0), 32'h234);
    chk(cfg_thr[19:10] == 10'h123, "R11 cfg_thr slot1", 32'(cfg_thr[19:10]), 32'h123);
    chk(cfg_thr[9:0] == 10'h3FF, "R11 cfg_thr slot0", 32'(cfg_thr[9:0]), 32'h3FF);
    chk(cfg_csr2 == 16'hF0F1, "R11 cfg_csr2", 32'(cfg_csr2), 32'hF0F1);
    chk(cfg_fmd[47:32] == 16'h0E00, "R11 cfg_fmd slot2", 32'(cfg_fmd[47:32]), 32'h0E00);
    chk(cfg_fmd[207:192] == 16'h01CD, "R11 cfg_fmd multi-event", 32'(cfg_fmd[207:192]), 32'h01CD);

    // R3: live value tracks the input
    mon_vals[19:10] = 10'h3C3;
    issue(1'b0, 1'b0, 1'b0, 7'h07, 16'h0);
    chk(rd_valid && rd_data == 16'h03C3, "R3 live monitor", 32'(rd_data), 32'h03C3);

    // R4: strobe lasts one cycle
    issue(1'b1, 1'b0, 1'b0, 7'h1D, 16'h0);
    chk(cmd_pulse == 10'h080, "R4 strobe position", 32'(cmd_pulse), 32'h080);
    @(negedge clk);
    chk(cmd_pulse == 10'h000, "R4 strobe width", 32'(cmd_pulse), 32'h000);

    // R10: idle cycles stay quiet
    repeat (2) @(negedge clk);
    chk({rd_valid, acc_err, rd_data, cmd_pulse} == '0, "R10 idle",
        32'({rd_valid, acc_err, rd_data, cmd_pulse}), 32'h0);

    // R1: a later reset restores defaults
    rst = 1'b1;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(cfg_csr0 == 11'h7FF, "R1 csr0 after reset", 32'(cfg_csr0), 32'h7FF);
    chk(cfg_thr[19:10] == 10'h3FF, "R1 threshold after reset", 32'(cfg_thr[19:10]), 32'h3FF);
    issue(1'b0, 1'b0, 1'b0, 7'h13, 16'h0);
    chk(rd_data == 16'h000F, "R1 csr2 readback after reset", 32'(rd_data), 32'h000F);

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_tests++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule